// File: doc/BRIEF.md
# Serial Avionics Word Transmitter

This block takes 32-bit avionics data words from a host, buffers them, and sends each one serially as return-to-zero pulses on a pair of logic-level outputs. One output carries the ones and the other carries the zeros. An external line driver turns the pair into bus levels. The host delivers each word in two 16-bit beats over a valid/ready stream. The first beat holds word bits 16..1 and the second holds bits 32..17. The two beats are joined into one entry of a 32-entry queue.

Bit timing comes from a strobe that pulses once per microsecond. The `rate_slow` input selects one of two bit rates:

- 100 kbit/s: 10 strobes per bit.
- 12.5 kbit/s: 80 strobes per bit.

This setting is separate from any receive path. The `par_gen` control decides what goes out in bit 32:

- `par_gen` = 1: bit 32 is replaced by a generated odd-parity bit.
- `par_gen` = 0: bit 32 is sent as the host wrote it.

Sending begins only while `tx_en` is high. A word that has started always finishes, even if `tx_en` falls. Every word is followed by four null bit times.

Back-pressure works as follows. A first beat is always accepted. A second beat is held off (`wr_ready` low) while the queue is full, and it is accepted in the first cycle the queue has space. A beat transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_data` must stay stable while `wr_valid` is high and `wr_ready` is low.

Top module: `a429_tx`

## Requirements
- R1: The first accepted beat after reset, or after a completed pair, supplies word bits 16..1 (`wr_data[15:0]` → word[15:0]). The next accepted beat supplies bits 32..17. `wr_ready` is high except when a second beat is pending and the queue holds 32 words.
- R2: The queue holds up to 32 words. Words are sent in the order they were completed, and none is lost or duplicated.
- R3: `fifo_full` is high exactly when 32 words are queued. `fifo_half` is high exactly when 16 or more words are queued. A word counts as queued from the edge that accepts its second beat until the edge where its transmission starts.
- R4: With `par_gen` = 1 when a word starts, the transmitted bit 32 is chosen so that the 32 sent bits hold an odd number of ones. With `par_gen` = 0, the host's bit 32 is sent unchanged.
- R5: Bits leave in the order bit 1 (word[0]) first through bit 32 (word[31]) last.
- R6: Each bit lasts one bit time counted in `tick_1us` strobes. For the first half of the bit, `line_hi` is high for a one or `line_lo` is high for a zero. For the second half, both are low. The two outputs are never high together.
- R7: `rate_slow` is sampled when a word starts: 0 gives 10 strobes per bit and 1 gives 80. Changing it mid-word does not alter that word's timing.
- R8: After the 32nd bit, both lines stay low for exactly four bit times before the serializer can start another word.
- R9: A word starts in the cycle after the serializer is idle with `tx_en` high and the queue not empty. Lowering `tx_en` during a word or its gap does not cut it short.
- R10: `tx_ready` is high exactly when the queue is empty and the serializer is neither sending nor in the inter-word gap.
- R11: After reset the queue is empty, both lines are low, `tx_ready` and `wr_ready` are high, and the next beat is taken as a first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle strobe, once per microsecond |
| wr_valid | input | 1 | Host beat valid |
| wr_ready | output | 1 | Beat can be accepted |
| wr_data | input | 16 | Host beat (low half first, then high half) |
| rate_slow | input | 1 | 1 = 12.5 kbit/s, 0 = 100 kbit/s |
| par_gen | input | 1 | 1 = bit 32 is generated odd parity |
| tx_en | input | 1 | Allows new words to start |
| line_hi | output | 1 | Return-to-zero pulse for a one bit |
| line_lo | output | 1 | Return-to-zero pulse for a zero bit |
| fifo_half | output | 1 | 16 or more words queued |
| fifo_full | output | 1 | 32 words queued |
| tx_ready | output | 1 | Queue empty and serializer idle |

## Verification
The assertions watch the following on every cycle:
- No beat is ever pushed into a full queue.
- The full flag always implies the half flag.
- Every word start happens with `tx_en` high.
- A freshly loaded word has odd parity when generation was selected.
- The serializer reaches a new word only through the idle state.
- No pulse appears while `tx_ready` is high.

The bench covers what only whole scenarios can show:
- Bit order and parity as seen on the line.
- Pulse widths at both rates, including a rate change mid-word.
- The exact four-bit gap.
- Back-pressure of a second beat against a full queue.
- Completion of a word after `tx_en` drops.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_SEND = 2'd1,
    SER_GAP  = 2'd2
  } ser_state_e;

  function automatic logic odd_fill(input logic [30:0] low_bits);
    return ~(^low_bits);
  endfunction
endpackage

// File: rtl/a429_tx_assembler.sv
module a429_tx_assembler #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [HALF_W-1:0]   wr_data,
  input  logic                q_full,
  output logic                push,
  output logic [2*HALF_W-1:0] push_word
);
  logic              have_lo;
  logic [HALF_W-1:0] lo_q;
  logic              fire;

  assign wr_ready  = !have_lo || !q_full;
  assign fire      = wr_valid && wr_ready;
  assign push      = fire && have_lo;
  assign push_word = {wr_data, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_lo <= 1'b0;
      lo_q    <= '0;
    end else if (fire) begin
      have_lo <= !have_lo;
      if (!have_lo) lo_q <= wr_data;
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !q_full);
endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_word,
  input  logic             pop,
  output logic [WIDTH-1:0] head_word,
  output logic             empty,
  output logic             full,
  output logic             half
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  assign head_word = mem[rd_ptr];
  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign half      = (count >= CW'(DEPTH / 2));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  full_has_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> half);
  // R2
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
  import a429_tx_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FAST_TICKS = 10,
  parameter int SLOW_TICKS = 80,
  parameter int GAP_BITS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rate_slow,
  input  logic              par_gen,
  input  logic              tx_en,
  input  logic              q_empty,
  input  logic [WORD_W-1:0] head_word,
  output logic              pop,
  output logic              line_hi,
  output logic              line_lo,
  output logic              idle
);
  localparam int TW = $clog2(SLOW_TICKS + 1);
  localparam int BW = $clog2(WORD_W);
  localparam logic [TW-1:0] FAST_LAST = TW'(FAST_TICKS - 1);
  localparam logic [TW-1:0] SLOW_LAST = TW'(SLOW_TICKS - 1);
  localparam logic [TW-1:0] FAST_HALF = TW'(FAST_TICKS / 2);
  localparam logic [TW-1:0] SLOW_HALF = TW'(SLOW_TICKS / 2);

  ser_state_e        state;
  logic [WORD_W-1:0] shreg;
  logic [BW-1:0]     bit_idx;
  logic [TW-1:0]     tcnt;
  logic              rate_q;
  logic [TW-1:0]     last_tick, half_tick;
  logic              bit_end, active;
  logic [WORD_W-1:0] load_word;

  assign last_tick = rate_q ? SLOW_LAST : FAST_LAST;
  assign half_tick = rate_q ? SLOW_HALF : FAST_HALF;
  assign bit_end   = tick && (tcnt == last_tick);
  assign pop       = (state == SER_IDLE) && tx_en && !q_empty;
  assign idle      = (state == SER_IDLE);
  assign active    = (state == SER_SEND) && (tcnt < half_tick);
  assign line_hi   = active && shreg[0];
  assign line_lo   = active && !shreg[0];

  always_comb begin
    load_word = head_word;
    if (par_gen) load_word[WORD_W-1] = odd_fill(head_word[WORD_W-2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SER_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      tcnt    <= '0;
      rate_q  <= 1'b0;
    end else begin
      case (state)
        SER_IDLE: if (pop) begin
          state   <= SER_SEND;
          shreg   <= load_word;
          bit_idx <= '0;
          tcnt    <= '0;
          rate_q  <= rate_slow;
        end
        SER_SEND: if (tick) begin
          if (bit_end) begin
            tcnt  <= '0;
            shreg <= shreg >> 1;
            if (bit_idx == BW'(WORD_W - 1)) begin
              state   <= SER_GAP;
              bit_idx <= '0;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        SER_GAP: if (tick) begin
          if (bit_end) begin
            tcnt <= '0;
            if (bit_idx == BW'(GAP_BITS - 1)) begin
              state   <= SER_IDLE;
              bit_idx <= '0;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= SER_IDLE;
      endcase
    end
  end

  // R9
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SER_SEND && $past(state) == SER_IDLE) |-> $past(tx_en));
  // R4
  par_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SER_SEND && $past(state) == SER_IDLE && $past(par_gen)) |-> (^shreg));
  // R8
  gap_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SER_SEND && $past(state) != SER_SEND) |-> $past(state) == SER_IDLE);
  // R7
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SER_IDLE && $past(state) != SER_IDLE) |-> $stable(rate_q));
endmodule

// File: rtl/a429_tx.sv
module a429_tx #(
  parameter int HALF_W     = 16,
  parameter int DEPTH      = 32,
  parameter int FAST_TICKS = 10,
  parameter int SLOW_TICKS = 80,
  parameter int GAP_BITS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              rate_slow,
  input  logic              par_gen,
  input  logic              tx_en,
  output logic              line_hi,
  output logic              line_lo,
  output logic              fifo_half,
  output logic              fifo_full,
  output logic              tx_ready
);
  localparam int WORD_W = 2 * HALF_W;

  logic              push, pop, q_empty, ser_idle;
  logic [WORD_W-1:0] push_word, head_word;

  a429_tx_assembler #(.HALF_W(HALF_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .q_full(fifo_full), .push(push), .push_word(push_word)
  );

  a429_tx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word), .pop(pop),
    .head_word(head_word), .empty(q_empty), .full(fifo_full), .half(fifo_half)
  );

  a429_tx_serializer #(
    .WORD_W(WORD_W), .FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS),
    .GAP_BITS(GAP_BITS)
  ) u_ser (
    .clk(clk), .rst_n(rst_n), .tick(tick_1us), .rate_slow(rate_slow),
    .par_gen(par_gen), .tx_en(tx_en), .q_empty(q_empty), .head_word(head_word),
    .pop(pop), .line_hi(line_hi), .line_lo(line_lo), .idle(ser_idle)
  );

  assign tx_ready = q_empty && ser_idle;

  // R10
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!line_hi && !line_lo));
  // R6
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_hi && line_lo));
endmodule

// File: tb/sim_a429_tx.sv
module sim_a429_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1us = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rate_slow = 1'b0;
  logic        par_gen = 1'b0;
  logic        tx_en = 1'b0;
  logic        wr_ready, line_hi, line_lo, fifo_half, fifo_full, tx_ready;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  a429_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rate_slow(rate_slow),
    .par_gen(par_gen), .tx_en(tx_en), .line_hi(line_hi), .line_lo(line_lo),
    .fifo_half(fifo_half), .fifo_full(fifo_full), .tx_ready(tx_ready)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // strobe every second clock
  initial begin
    forever begin
      @(posedge clk); #1;
      tick_1us = ~tick_1us;
    end
  end

  // ---------------- behavioural reference model ----------------
  int unsigned mq[$];
  bit          m_have_lo;
  logic [15:0] m_lo;
  int          m_st;       // 0 idle, 1 sending, 2 gap
  int          m_bit, m_tc, m_bt;
  logic [31:0] m_word;

  function automatic logic [31:0] fix_par(input logic [31:0] w, input bit gen);
    logic [31:0] r = w;
    if (gen) r[31] = ~(^w[30:0]);
    return r;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_have_lo = 0; m_lo = '0; m_st = 0; m_bit = 0; m_tc = 0; m_bt = 10; m_word = '0;
    end else begin
      bit exp_hi, exp_lo, exp_rdy;
      exp_hi  = (m_st == 1) && (m_tc < m_bt / 2) && m_word[m_bit];
      exp_lo  = (m_st == 1) && (m_tc < m_bt / 2) && !m_word[m_bit];
      exp_rdy = !m_have_lo || (mq.size() < 32);
      check(line_hi == exp_hi && line_lo == exp_lo, "R6 line pair", {line_hi, line_lo}, {exp_hi, exp_lo});
      check(fifo_full == (mq.size() == 32) && fifo_half == (mq.size() >= 16), "R3 flags",
            {fifo_full, fifo_half}, {mq.size() == 32, mq.size() >= 16});
      check(tx_ready == (mq.size() == 0 && m_st == 0), "R10 tx_ready", tx_ready, (mq.size() == 0 && m_st == 0));
      check(wr_ready == exp_rdy, "R1 wr_ready", wr_ready, exp_rdy);
      // next state
      if (m_st == 0 && tx_en && mq.size() > 0) begin
        m_word = fix_par(mq.pop_front(), par_gen);
        m_st = 1; m_bit = 0; m_tc = 0; m_bt = rate_slow ? 80 : 10;
      end else if (m_st != 0 && tick_1us) begin
        if (m_tc == m_bt - 1) begin
          m_tc = 0;
          if (m_st == 1) begin
            if (m_bit == 31) begin m_st = 2; m_bit = 0; end else m_bit++;
          end else begin
            if (m_bit == 3) begin m_st = 0; m_bit = 0; end else m_bit++;
          end
        end else m_tc++;
      end
      if (wr_valid && exp_rdy) begin
        if (m_have_lo) begin mq.push_back({wr_data, m_lo}); m_have_lo = 0; end
        else begin m_lo = wr_data; m_have_lo = 1; end
      end
    end
  end

  // ---------------- line decoder ----------------
  logic [31:0] expq[$];
  logic [31:0] dec_word;
  int          dec_n = 0;
  int          words_seen = 0;
  int          pw_cnt = 0, last_width = 0;
  bit          prev_act = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      dec_n = 0; prev_act = 0; pw_cnt = 0;
    end else begin
      bit act;
      act = line_hi | line_lo;
      if (act && !prev_act) begin
        dec_word[dec_n] = line_hi;
        dec_n++;
        pw_cnt = 0;
      end
      if (act) pw_cnt++;
      if (!act && prev_act) last_width = pw_cnt;
      prev_act = act;
      if (dec_n == 32) begin
        logic [31:0] e;
        dec_n = 0;
        words_seen++;
        e = (expq.size() > 0) ? expq.pop_front() : 32'hDEAD_BEEF;
        check(dec_word == e, "R5/R4/R2 decoded word", dec_word, e);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic beat(input logic [15:0] d);
    wr_valid = 1'b1; wr_data = d;
    forever begin @(negedge clk); if (wr_ready) break; end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    expq.push_back(fix_par(w, par_gen));
    beat(w[15:0]);
    beat(w[31:16]);
  endtask

  task automatic drain();
    int guard = 0;
    do begin @(negedge clk); guard++; end
    while (!(tx_ready && expq.size() == 0 && dec_n == 0) && guard < 60000);
    repeat (200) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(tx_ready == 1'b1, "R11 tx_ready", tx_ready, 1);
    check(wr_ready == 1'b1, "R11 wr_ready", wr_ready, 1);
    check({line_hi, line_lo, fifo_half, fifo_full} == 4'b0, "R11 lines/flags",
          {line_hi, line_lo, fifo_half, fifo_full}, 0);
    @(posedge clk); #1;

    // R9 + R4: queued while disabled, generated parity
    par_gen = 1'b1;
    send_word(32'h0000_0000);
    send_word(32'h8000_0001);
    send_word(32'hA5A5_1234);
    repeat (400) @(negedge clk);
    check(words_seen == 0 && !line_hi && !line_lo, "R9 no start while disabled", words_seen, 0);
    check(tx_ready == 1'b0, "R10 not ready with queued words", tx_ready, 0);
    @(posedge clk); #1;
    tx_en = 1'b1;
    drain();
    check(words_seen == 3, "R4 parity words sent", words_seen, 3);

    // R4 pass-through bit 32
    @(posedge clk); #1;
    par_gen = 1'b0;
    send_word(32'hFFFF_FFFF);
    send_word(32'h8000_0000);
    drain();
    check(words_seen == 5, "R4 raw words sent", words_seen, 5);

    // R1/R3: fill queue while disabled
    @(posedge clk); #1;
    tx_en = 1'b0;
    for (int i = 0; i < 32; i++) begin
      send_word(32'h1000_0000 + i * 32'h0101_0103);
      if (i == 14) begin @(negedge clk); check(fifo_half == 1'b0, "R3 half at 15", fifo_half, 0); @(posedge clk); #1; end
      if (i == 15) begin @(negedge clk); check(fifo_half == 1'b1, "R3 half at 16", fifo_half, 1); @(posedge clk); #1; end
    end
    @(negedge clk);
    check(fifo_full == 1'b1, "R3 full at 32", fifo_full, 1);
    @(posedge clk); #1;
    expq.push_back(32'h7777_5555);
    beat(16'h5555);
    wr_valid = 1'b1; wr_data = 16'h7777;
    repeat (5) @(negedge clk);
    check(wr_ready == 1'b0, "R1 second beat held when full", wr_ready, 0);
    @(posedge clk); #1;
    tx_en = 1'b1;
    forever begin @(negedge clk); if (wr_ready) break; end
    @(posedge clk); #1;
    wr_valid = 1'b0;
    drain();
    check(words_seen == 38, "R2 all 33 queued words sent", words_seen, 38);

    // R7: slow rate, change mid-word
    @(posedge clk); #1;
    rate_slow = 1'b1;
    send_word(32'h0F0F_3C3C);
    repeat (300) @(negedge clk);
    @(posedge clk); #1;
    rate_slow = 1'b0;
    repeat (400) @(negedge clk);
    check(last_width == 80, "R7 slow pulse width held", last_width, 80);
    drain();
    check(words_seen == 39, "R7 slow word sent", words_seen, 39);

    // R9: tx_en drop mid-word, next word waits
    @(posedge clk); #1;
    tx_en = 1'b0;
    send_word(32'h1234_5678);
    send_word(32'h9ABC_DEF0);
    @(posedge clk); #1;
    tx_en = 1'b1;
    repeat (100) @(negedge clk);
    @(posedge clk); #1;
    tx_en = 1'b0;
    repeat (1500) @(negedge clk);
    check(words_seen == 40, "R9 word completes after disable", words_seen, 40);
    check(dec_n == 0 && tx_ready == 1'b0, "R9 next word held", dec_n, 0);
    check(last_width == 10, "R6 fast pulse width", last_width, 10);
    @(posedge clk); #1;
    tx_en = 1'b1;
    drain();
    check(words_seen == 41, "R8 final word after gap", words_seen, 41);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule